// File: doc/BRIEF.md
# Multi-Cycle Byte Divider

This block divides an unsigned 8-bit dividend by an unsigned 8-bit divisor. It returns an 8-bit quotient, which goes to the accumulator, and an 8-bit remainder, which goes to the B register. It also returns a carry flag and an overflow flag. A request is made by raising `start` while the block is idle. The block then stays busy for a fixed four cycles and raises `done` for one cycle at the end. A request made while the block is busy is ignored.

The datapath is a restoring shift-subtract divider. Each cycle it chains two trial-subtract stages, so it resolves two quotient bits per cycle. The carry flag is always cleared. A zero divisor is reported on the overflow flag, and no exception is raised. For a zero divisor the results are still defined: quotient FFh and remainder equal to the dividend. These fall out of the same subtract chain with no special path.

Top module: `bytediv_top`

## Requirements
- R1: For a non-zero divisor, when `done` is high, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor, both unsigned. For example, 251/18 gives quotient 0Dh and remainder 11h.
- R2: An accepted request keeps `busy` high for exactly 4 cycles, counted from the clock edge that accepts it, and `done` is high only in the 4th of those cycles.
- R3: `done` is a single-cycle pulse and is never high while `busy` is low.
- R4: A `start` asserted while `busy` is high is ignored. The running operation finishes on its original schedule with its original operands, and no new operation begins.
- R5: `carry_flag` reads 0 at all times, including on a zero divisor.
- R6: For a non-zero divisor, `ovf_flag` is 0 when `done` is high.
- R7: For a zero divisor, `ovf_flag` is 1 when `done` is high, `quotient` is FFh and `remainder` equals the dividend.
- R8: After `done`, `quotient`, `remainder` and `ovf_flag` hold their values until the next request is accepted, whatever the operand inputs do.
- R9: During and after reset, `busy`, `done`, `quotient`, `remainder` and `ovf_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request a division; taken only while idle |
| dividend | input | 8 | Unsigned dividend, sampled on the accepting edge |
| divisor | input | 8 | Unsigned divisor, sampled on the accepting edge |
| busy | output | 1 | High for the four cycles of an operation |
| done | output | 1 | One-cycle pulse in the final cycle; results valid |
| quotient | output | 8 | Quotient (accumulator result) |
| remainder | output | 8 | Remainder (B register result) |
| carry_flag | output | 1 | Carry flag, always cleared |
| ovf_flag | output | 1 | Overflow flag, set for a zero divisor |

## Verification
The bench aims at the operand extremes: divisor 1, divisor FFh, a dividend of zero, equal operands and a dividend smaller than the divisor. A stage that mishandles the borrow, or drops the top bit of the partial remainder, returns a wrong quotient bit at one of these points. It also checks a zero divisor. A divider that special-cased it badly, or did not raise overflow, would return other values or leave the flag clear. A start pulse is sent while the block is busy, carrying different operands. A design that restarted on it would stretch `busy` or report the second division. The operand inputs are changed after completion. A design that did not hold its results would let them drift.

// File: rtl/bdiv_pkg.sv
package bdiv_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bdiv_state_e;

endpackage

// File: rtl/bdiv_stage.sv
// One restoring trial-subtract: shift a dividend bit into the partial
// remainder, subtract the divisor, keep the difference if no borrow.
module bdiv_stage #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] rem_in,
  input  logic             bit_in,
  input  logic [WIDTH-1:0] dvs,
  output logic [WIDTH-1:0] rem_out,
  output logic             q_bit
);

  logic [WIDTH:0]   part;
  logic [WIDTH+1:0] diff;
  logic             borrow;

  always_comb begin
    part    = {rem_in, bit_in};
    diff    = {1'b0, part} - {2'b00, dvs};
    borrow  = diff[WIDTH+1];
    q_bit   = ~borrow;
    rem_out = borrow ? part[WIDTH-1:0] : diff[WIDTH-1:0];
  end

endmodule

// File: rtl/bdiv_step.sv
// Chains BITS_PER_CYC trial-subtract stages; resolves that many quotient
// bits in one cycle. The quotient shifts in from the bottom while the
// remaining dividend bits leave from the top of the same register.
module bdiv_step #(
  parameter int WIDTH        = 8,
  parameter int BITS_PER_CYC = 2
) (
  input  logic [WIDTH-1:0] rem_in,
  input  logic [WIDTH-1:0] quo_in,
  input  logic [WIDTH-1:0] dvs,
  output logic [WIDTH-1:0] rem_out,
  output logic [WIDTH-1:0] quo_out
);

  logic [WIDTH-1:0] rem_chain [BITS_PER_CYC+1];
  logic [WIDTH-1:0] quo_chain [BITS_PER_CYC+1];

  assign rem_chain[0] = rem_in;
  assign quo_chain[0] = quo_in;

  for (genvar g = 0; g < BITS_PER_CYC; g++) begin : g_stage
    logic qb;
    bdiv_stage #(.WIDTH(WIDTH)) u_stage (
      .rem_in  (rem_chain[g]),
      .bit_in  (quo_chain[g][WIDTH-1]),
      .dvs     (dvs),
      .rem_out (rem_chain[g+1]),
      .q_bit   (qb)
    );
    assign quo_chain[g+1] = {quo_chain[g][WIDTH-2:0], qb};
  end

  assign rem_out = rem_chain[BITS_PER_CYC];
  assign quo_out = quo_chain[BITS_PER_CYC];

endmodule

// File: rtl/bdiv_ctrl.sv
// Sequencer: accepts a request when idle, counts the fixed number of
// steps, flags the last cycle.
module bdiv_ctrl
  import bdiv_pkg::*;
#(
  parameter int STEPS = 4,
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step_en,
  output logic busy,
  output logic done
);

  bdiv_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last = (cnt_q == CNT_W'(STEPS));

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    step_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          step_en = 1'b1;
          st_d    = ST_RUN;
          cnt_d   = CNT_W'(1);
        end
      end
      ST_RUN: begin
        if (last) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          step_en = 1'b1;
          cnt_d   = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q == ST_RUN);
  assign done = busy && last;

endmodule

// File: rtl/bytediv_top.sv
module bytediv_top #(
  parameter int WIDTH        = 8,
  parameter int BITS_PER_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             carry_flag,
  output logic             ovf_flag
);

  localparam int STEPS = WIDTH / BITS_PER_CYC;
  localparam int CNT_W = $clog2(STEPS + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic accept, step_en;

  bdiv_ctrl #(.STEPS(STEPS), .CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start),
    .accept  (accept),
    .step_en (step_en),
    .busy    (busy),
    .done    (done)
  );

  logic [WIDTH-1:0] rem_q, quo_q, dvs_q;
  logic [WIDTH-1:0] rem_d, quo_d, dvs_d;
  logic [WIDTH-1:0] rem_src, quo_src, dvs_src;
  logic [WIDTH-1:0] rem_nx, quo_nx;
  logic             ovf_q, ovf_d, cy_q, cy_d;

  // step operands: fresh from the ports on the accepting edge
  always_comb begin
    if (accept) begin
      rem_src = '0;
      quo_src = dividend;
      dvs_src = divisor;
    end else begin
      rem_src = rem_q;
      quo_src = quo_q;
      dvs_src = dvs_q;
    end
  end

  bdiv_step #(.WIDTH(WIDTH), .BITS_PER_CYC(BITS_PER_CYC)) u_step (
    .rem_in  (rem_src),
    .quo_in  (quo_src),
    .dvs     (dvs_src),
    .rem_out (rem_nx),
    .quo_out (quo_nx)
  );

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    dvs_d = dvs_q;
    ovf_d = ovf_q;
    cy_d  = cy_q;
    if (step_en) begin
      rem_d = rem_nx;
      quo_d = quo_nx;
    end
    if (accept) begin
      dvs_d = divisor;
      ovf_d = (divisor == '0);
      cy_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      ovf_q <= 1'b0;
      cy_q  <= 1'b0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
      ovf_q <= ovf_d;
      cy_q  <= cy_d;
    end
  end

  assign quotient   = quo_q;
  assign remainder  = rem_q;
  assign ovf_flag   = ovf_q;
  assign carry_flag = cy_q;

endmodule

// File: rtl/bdiv_checker.sv
module bdiv_checker #(
  parameter int WIDTH        = 8,
  parameter int BITS_PER_CYC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic             carry_flag,
  input logic             ovf_flag
);

  localparam int STEPS = WIDTH / BITS_PER_CYC;
  localparam int LAT_W = $clog2(STEPS + 2);

  logic [WIDTH-1:0] dvd_cap, dvs_cap;
  logic [LAT_W-1:0] lat_cnt;
  logic [2*WIDTH-1:0] recon;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_cap <= '0;
      dvs_cap <= '0;
      lat_cnt <= '0;
    end else if (start && !busy) begin
      dvd_cap <= dividend;
      dvs_cap <= divisor;
      lat_cnt <= LAT_W'(1);
    end else if (busy) begin
      lat_cnt <= lat_cnt + LAT_W'(1);
    end
  end

  assign recon = quotient * dvs_cap + {{WIDTH{1'b0}}, remainder};

  // R1
  p_quot_rem_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dvs_cap != '0) |->
      (recon == {{WIDTH{1'b0}}, dvd_cap} && remainder < dvs_cap));

  // R2
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == LAT_W'(STEPS)));

  p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R3
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  p_ignore_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);

  // R5
  p_carry_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !carry_flag);

  // R6 and R7
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dvs_cap != '0) |-> !ovf_flag);

  p_zero_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dvs_cap == '0) |->
      (ovf_flag && quotient == {WIDTH{1'b1}} && remainder == dvd_cap));

  // R8
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=>
      ($stable(quotient) && $stable(remainder) && $stable(ovf_flag)));

endmodule

bind bytediv_top bdiv_checker #(.WIDTH(WIDTH), .BITS_PER_CYC(BITS_PER_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .dividend   (dividend),
  .divisor    (divisor),
  .busy       (busy),
  .done       (done),
  .quotient   (quotient),
  .remainder  (remainder),
  .carry_flag (carry_flag),
  .ovf_flag   (ovf_flag)
);

// File: tb/sim_bytediv_top.sv
`timescale 1ns/1ps
module sim_bytediv_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] dividend, divisor;
  logic       busy, done, carry_flag, ovf_flag;
  logic [7:0] quotient, remainder;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bytediv_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dividend   (dividend),
    .divisor    (divisor),
    .busy       (busy),
    .done       (done),
    .quotient   (quotient),
    .remainder  (remainder),
    .carry_flag (carry_flag),
    .ovf_flag   (ovf_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R9: reset state
  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; dividend = 8'h00; divisor = 8'h00;
    cyc(3);
    chk("R9 busy", busy, 0); chk("R9 done", done, 0);
    chk("R9 quotient", quotient, 0); chk("R9 remainder", remainder, 0);
    chk("R9 ovf", ovf_flag, 0);
    rst_n = 1'b1;
    cyc(3);
    chk("R9 busy after release", busy, 0);
    chk("R9 quotient after release", quotient, 0);
  endtask

  // full operation with timing checks (R1, R2, R3, R5, R6, R7)
  task automatic t_divide(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] eq, er;
    if (b == 8'h00) begin eq = 8'hFF; er = a; end
    else begin eq = a / b; er = a % b; end
    dividend = a; divisor = b; start = 1'b1;
    cyc(1);            // accepted on this edge
    start = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      chk("R2 busy in run", busy, 1);
      chk("R3 done early", done, 0);
      cyc(1);
    end
    chk("R2 busy in last", busy, 1);
    chk("R2 done in 4th cycle", done, 1);
    if (b == 8'h00) begin
      chk("R7 quotient", quotient, eq);
      chk("R7 remainder", remainder, er);
      chk("R7 ovf", ovf_flag, 1);
    end else begin
      chk("R1 quotient", quotient, eq);
      chk("R1 remainder", remainder, er);
      chk("R6 ovf", ovf_flag, 0);
    end
    chk("R5 carry", carry_flag, 0);
    cyc(1);
    chk("R2 busy drops", busy, 0);
    chk("R3 done single", done, 0);
  endtask

  // R4: start while busy is ignored
  task automatic t_start_busy();
    dividend = 8'd200; divisor = 8'd7; start = 1'b1;
    cyc(1);
    dividend = 8'd9; divisor = 8'd0;   // start stays high with new operands
    cyc(2);
    chk("R4 no done yet", done, 0);
    cyc(1);
    start = 1'b0;
    chk("R4 done on schedule", done, 1);
    chk("R4 quotient of first op", quotient, 8'd28);
    chk("R4 remainder of first op", remainder, 8'd4);
    chk("R4 ovf of first op", ovf_flag, 0);
    cyc(1);
    chk("R4 no new op", busy, 0);
    cyc(2);
    chk("R4 still idle", busy, 0);
  endtask

  // R8: results held while operands change
  task automatic t_hold();
    t_divide(8'd100, 8'd9);
    dividend = 8'h55; divisor = 8'h00;
    cyc(2);
    dividend = 8'hAA; divisor = 8'h03;
    cyc(2);
    chk("R8 quotient held", quotient, 8'd11);
    chk("R8 remainder held", remainder, 8'd1);
    chk("R8 ovf held", ovf_flag, 0);
    chk("R8 idle", busy, 0);
  endtask

  task automatic t_patterns();
    t_divide(8'd251, 8'd18);
    t_divide(8'hFF, 8'h01);
    t_divide(8'h00, 8'h05);
    t_divide(8'h07, 8'hFF);
    t_divide(8'hC8, 8'hC8);
    t_divide(8'h01, 8'h02);
    t_divide(8'hFF, 8'h10);
    t_divide(8'h80, 8'h03);
  endtask

  task automatic t_zero();
    t_divide(8'h3C, 8'h00);
    t_divide(8'h00, 8'h00);
    t_divide(8'd50, 8'd6);   // flag clears again after a zero divisor
  endtask

  task automatic t_sweep();
    for (int a = 0; a < 256; a += 37)
      for (int b = 0; b < 256; b += 29)
        t_divide(8'(a), 8'(b));
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_patterns();
    t_zero();
    t_start_busy();
    t_hold();
    t_sweep();
    cyc(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule